// File: doc/BRIEF.md
# Delayed Two-Slot Signal Channel

The block models one direction of a point-to-point link. The link carries three symbolic line signals, request, acknowledge and idle, from a sender to a receiver with a bounded propagation delay. On each tick the sender can present one signal code. The channel holds at most two different signals in flight. Each held signal has its own age counter. When the older held signal has aged for `DELAY` ticks, the channel presents it to the receiver as a one-tick strobe that carries the signal code. A full link is built from two instances, one for each direction.

The controller has ten named states. `S_EMPTY` holds nothing. `S_REQ`, `S_ACK` and `S_IDLE` hold a single signal. Six ordered pair states hold two signals, written oldest first: `S_REQ_ACK`, `S_ACK_IDLE`, `S_IDLE_REQ`, `S_ACK_REQ`, `S_REQ_IDLE` and `S_IDLE_ACK`. The transitions are:

- **send-new**: `S_EMPTY` moves to a single state.
- **send-queue**: a single state moves to the pair state that starts with the held signal.
- **deliver-last**: a single state moves to `S_EMPTY`.
- **deliver-shift**: a pair state moves to the single state of its newer signal.
- **absorb**: a send equal to the newest held signal keeps the state.
- **drop**: a send that differs from the newer signal while two are held keeps the state and raises the overflow flag.

Within a tick, a delivery is applied first, and then the send is applied to whatever remains.

Top module: `sig_link_lane`

## Requirements
- R1: After synchronous reset the channel is `S_EMPTY`, `rcv_stb` is 0, `rcv_code` is 00 and `ovf` is 0.
- R2: Signal codes on `snd_code` and `rcv_code` are 00 none, 01 request, 10 acknowledge and 11 idle. A signal sent in cycle t into an empty channel is presented with its own code in cycle t+DELAY+1, with `rcv_stb` high for exactly that one cycle.
- R3: A send equal to the newest held signal is absorbed. Only one delivery results, and its timing is set by the first send.
- R4: A different signal sent in cycle t2 while one signal is held is queued behind it. The two are delivered oldest first, and the newer one is delivered in cycle t2+DELAY+1 because its age runs on its own counter.
- R5: When a delivery and a send fall in the same cycle, the delivery is applied first. A send equal to the delivered code therefore starts a new signal, and a send arriving while a pair is delivering joins the remaining signal without overflow.
- R6: While two signals are held, a send that differs from the newer one is dropped. It sets `ovf`, which stays 1 until reset. The two held signals are still delivered on time.
- R7: Ages do not advance in `S_EMPTY`, and the age of the oldest held signal never exceeds DELAY. A send after any idle gap still takes DELAY+1 cycles.
- R8: `rcv_stb` is high only in a delivery cycle, and `rcv_code` is 00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | tick clock |
| rst | input | 1 | synchronous reset, active high |
| snd_code | input | 2 | signal sent this tick (00 none) |
| rcv_stb | output | 1 | one-tick delivery strobe |
| rcv_code | output | 2 | delivered signal code, 00 when idle |
| ovf | output | 1 | sticky overflow flag for a dropped send |

## Verification
The delivery outputs are decoded combinationally from the state register. A send applied in cycle t therefore shows up in cycle t+DELAY+1 at the earliest. An overflow shows on `ovf` one cycle after the dropped send. The bench drives each input just after a rising edge and compares both outputs at the falling edge of every cycle, against a per-cycle expected list. That list is built arithmetically from the send cycles and DELAY, so a delivery that arrives a cycle early or late fails the check.

// File: rtl/sig_lane_pkg.sv
package sig_lane_pkg;

    typedef logic [1:0] sig_t;

    localparam sig_t SIG_NONE = 2'b00;
    localparam sig_t SIG_REQ  = 2'b01;
    localparam sig_t SIG_ACK  = 2'b10;
    localparam sig_t SIG_IDLE = 2'b11;

    typedef enum logic [3:0] {
        S_EMPTY    = 4'd0,
        S_REQ      = 4'd1,
        S_ACK      = 4'd2,
        S_IDLE     = 4'd3,
        S_REQ_ACK  = 4'd4,
        S_ACK_IDLE = 4'd5,
        S_IDLE_REQ = 4'd6,
        S_ACK_REQ  = 4'd7,
        S_REQ_IDLE = 4'd8,
        S_IDLE_ACK = 4'd9
    } lane_st_e;

    function automatic logic is_pair(lane_st_e s);
        return (s >= S_REQ_ACK) && (s <= S_IDLE_ACK);
    endfunction

    function automatic sig_t old_of(lane_st_e s);
        case (s)
            S_REQ, S_REQ_ACK, S_REQ_IDLE:   return SIG_REQ;
            S_ACK, S_ACK_IDLE, S_ACK_REQ:   return SIG_ACK;
            S_IDLE, S_IDLE_REQ, S_IDLE_ACK: return SIG_IDLE;
            default:                        return SIG_NONE;
        endcase
    endfunction

    function automatic sig_t new_of(lane_st_e s);
        case (s)
            S_REQ, S_IDLE_REQ, S_ACK_REQ:   return SIG_REQ;
            S_ACK, S_REQ_ACK, S_IDLE_ACK:   return SIG_ACK;
            S_IDLE, S_ACK_IDLE, S_REQ_IDLE: return SIG_IDLE;
            default:                        return SIG_NONE;
        endcase
    endfunction

    function automatic lane_st_e single_of(sig_t c);
        case (c)
            SIG_REQ:  return S_REQ;
            SIG_ACK:  return S_ACK;
            SIG_IDLE: return S_IDLE;
            default:  return S_EMPTY;
        endcase
    endfunction

    function automatic lane_st_e pair_of(sig_t older, sig_t newer);
        case ({older, newer})
            {SIG_REQ,  SIG_ACK}:  return S_REQ_ACK;
            {SIG_ACK,  SIG_IDLE}: return S_ACK_IDLE;
            {SIG_IDLE, SIG_REQ}:  return S_IDLE_REQ;
            {SIG_ACK,  SIG_REQ}:  return S_ACK_REQ;
            {SIG_REQ,  SIG_IDLE}: return S_REQ_IDLE;
            {SIG_IDLE, SIG_ACK}:  return S_IDLE_ACK;
            default:              return S_EMPTY;
        endcase
    endfunction

endpackage

// File: rtl/sig_lane_age.sv
module sig_lane_age #(
    parameter int DELAY = 36,
    parameter int AW    = $clog2(DELAY + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    output logic [AW-1:0] age
);
    localparam logic [AW-1:0] SAT = AW'(DELAY + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (ld) begin
            age <= ld_val;
        end else if (adv && (age != SAT)) begin
            age <= age + 1'b1;
        end
    end

    AST_AGE_SATURATES: assert property (@(posedge clk) disable iff (rst)
        age <= SAT) else $error("age above saturation"); // R7

endmodule

// File: rtl/sig_lane_ctrl.sv
module sig_lane_ctrl
    import sig_lane_pkg::*;
#(
    parameter int DELAY = 36,
    parameter int AW    = $clog2(DELAY + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  sig_t               snd_code,
    input  logic [1:0][AW-1:0] age,
    output logic [1:0]         ld,
    output logic [1:0][AW-1:0] ld_val,
    output logic [1:0]         adv,
    output logic               rcv_stb,
    output sig_t               rcv_code,
    output logic               ovf
);
    localparam logic [AW-1:0] DLY = AW'(DELAY);

    lane_st_e state, rem, nxt;
    logic     deliver, drop;
    sig_t     newest;

    // delivery first, then the send acts on what remains
    always_comb begin
        deliver = (state != S_EMPTY) && (age[0] == DLY);
        rem     = state;
        if (deliver) begin
            rem = is_pair(state) ? single_of(new_of(state)) : S_EMPTY;
        end
        newest = new_of(rem);
        nxt    = rem;
        drop   = 1'b0;
        if ((snd_code != SIG_NONE) && (snd_code != newest)) begin
            unique case (1'b1)
                (rem == S_EMPTY): nxt  = single_of(snd_code);
                is_pair(rem):     drop = 1'b1;
                default:          nxt  = pair_of(newest, snd_code);
            endcase
        end
    end

    // age slot control: slot 0 is the older signal, slot 1 the newer
    always_comb begin
        ld     = '0;
        ld_val = '0;
        adv    = '0;
        if (nxt == S_EMPTY) begin
            ld[0] = 1'b1;
        end else if (deliver && is_pair(state)) begin
            ld[0]     = 1'b1;
            ld_val[0] = age[1] + 1'b1;
        end else if ((state == S_EMPTY) || deliver) begin
            ld[0] = 1'b1;
        end else begin
            adv[0] = 1'b1;
        end
        if (is_pair(nxt) && is_pair(rem)) begin
            adv[1] = 1'b1;
        end else begin
            ld[1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_EMPTY;
            ovf   <= 1'b0;
        end else begin
            state <= nxt;
            ovf   <= ovf | drop;
        end
    end

    always_comb begin
        rcv_stb  = deliver;
        rcv_code = deliver ? old_of(state) : SIG_NONE;
    end

    AST_AGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state != S_EMPTY) |-> (age[0] <= DLY)) else $error("age past delay"); // R7
    AST_EMPTY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state == S_EMPTY) |-> (age[0] == '0 && age[1] == '0)) else $error("empty aging"); // R7
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
        is_pair(state) |-> (age[1] < age[0])) else $error("pair order"); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf) else $error("overflow cleared"); // R6
    AST_STB_CODE: assert property (@(posedge clk) disable iff (rst)
        rcv_stb |-> (rcv_code != SIG_NONE)) else $error("strobe without code"); // R2
    AST_QUIET_CODE: assert property (@(posedge clk) disable iff (rst)
        !rcv_stb |-> (rcv_code == SIG_NONE)) else $error("code without strobe"); // R8

endmodule

// File: rtl/sig_link_lane.sv
module sig_link_lane #(
    parameter int DELAY = 36
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] snd_code,
    output logic       rcv_stb,
    output logic [1:0] rcv_code,
    output logic       ovf
);
    localparam int AW = $clog2(DELAY + 2);

    logic [1:0][AW-1:0] age;
    logic [1:0][AW-1:0] ld_val;
    logic [1:0]         ld;
    logic [1:0]         adv;

    sig_lane_ctrl #(.DELAY(DELAY), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .snd_code (snd_code),
        .age      (age),
        .ld       (ld),
        .ld_val   (ld_val),
        .adv      (adv),
        .rcv_stb  (rcv_stb),
        .rcv_code (rcv_code),
        .ovf      (ovf)
    );

    for (genvar g = 0; g < 2; g++) begin : g_slot
        sig_lane_age #(.DELAY(DELAY), .AW(AW)) u_age (
            .clk    (clk),
            .rst    (rst),
            .ld     (ld[g]),
            .ld_val (ld_val[g]),
            .adv    (adv[g]),
            .age    (age[g])
        );
    end

endmodule

// File: tb/test_sig_link_lane.sv
module test_sig_link_lane;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 5;
    localparam int LEN        = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] snd_code = 2'b00;
    logic       rcv_stb;
    logic [1:0] rcv_code;
    logic       ovf;

    int n_chk  = 0;
    int n_fail = 0;

    logic [1:0] snd_at [0:LEN-1];
    logic [1:0] exp_at [0:LEN-1];
    int         ovf_from;

    always #(CLK_PERIOD/2) clk = ~clk;

    sig_link_lane #(.DELAY(D)) i_sig_link_lane (
        .clk      (clk),
        .rst      (rst),
        .snd_code (snd_code),
        .rcv_stb  (rcv_stb),
        .rcv_code (rcv_code),
        .ovf      (ovf)
    );

    task automatic clear_plan();
        for (int i = 0; i < LEN; i++) begin
            snd_at[i] = 2'b00;
            exp_at[i] = 2'b00;
        end
        ovf_from = 1000;
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        snd_code = 2'b00;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic check(input string tag, input int act, input int exp_v, input string what);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    task automatic play(input string tag);
        do_reset();
        for (int c = 0; c < LEN; c++) begin
            snd_code = snd_at[c];
            @(negedge clk);
            check(tag, int'(rcv_stb), int'(exp_at[c] != 2'b00), "rcv_stb");
            check(tag, int'(rcv_code), int'(exp_at[c]), "rcv_code");
            check((ovf_from < 1000) ? "R6" : tag, int'(ovf), int'(c >= ovf_from), "ovf");
            @(posedge clk);
            #1;
        end
        snd_code = 2'b00;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", int'(rcv_stb), 0, "rcv_stb");
        check("R1", int'(rcv_code), 0, "rcv_code");
        check("R1", int'(ovf), 0, "ovf");
        @(posedge clk);
        #1;

        // sweep: first signal a at cycle 0, second b at cycle g
        for (int a = 1; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int g = 1; g <= D + 2; g++) begin
                    string tag;
                    clear_plan();
                    snd_at[0]     = 2'(a);
                    snd_at[g]     = 2'(b);
                    exp_at[D + 1] = 2'(a);
                    if (b != 0 && !(b == a && g <= D)) exp_at[g + D + 1] = 2'(b);
                    if (b == 0)           tag = "R2";
                    else if (g == D + 1)  tag = "R5";
                    else if (b == a)      tag = "R3";
                    else if (g > D + 1)   tag = "R7";
                    else                  tag = "R4";
                    play(tag);
                end
            end
        end

        // R5: pair delivering while a third code arrives
        for (int c3 = 1; c3 < 4; c3++) begin
            clear_plan();
            snd_at[0]     = 2'b01;
            snd_at[1]     = 2'b10;
            snd_at[D + 1] = 2'(c3);
            exp_at[D + 1] = 2'b01;
            exp_at[D + 2] = 2'b10;
            if (c3 != 2) exp_at[2 * D + 2] = 2'(c3);
            play("R5");
        end

        // R6: drop while two are held, distinct third and repeat of older
        for (int k = 0; k < 2; k++) begin
            clear_plan();
            snd_at[0]     = 2'b01;
            snd_at[1]     = 2'b10;
            snd_at[2]     = (k == 0) ? 2'b11 : 2'b01;
            exp_at[D + 1] = 2'b01;
            exp_at[D + 2] = 2'b10;
            ovf_from      = 3;
            play("R6");
        end

        // R1: overflow cleared by reset
        do_reset();
        @(negedge clk);
        check("R1", int'(ovf), 0, "ovf after reset");
        check("R8", int'(rcv_stb), 0, "rcv_stb idle");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule